// File: doc/BRIEF.md
# Paired-View General Register File

This block is the general register storage of a 32-bit processor: sixty-four entries of 32 bits, reachable through several views at once. Two plain 32-bit read ports and one 32-bit write port serve integer work. A 64-bit path reads and writes floating registers, each built from two entries sixteen apart. Floating numbers 0 to 15 pair the low bank with the bank above it. Floating numbers 32 to 47 pair the third bank with the fourth. Three narrow lookups return the base, index and modification register that a 4-bit alias number selects.

Entry zero is a hard zero. Every view reads it as zero and drops every write to it, and this includes the upper half of floating register zero and modification alias zero. A floating number outside the two legal ranges raises an illegal flag, reads as zero and writes nothing. All reads are combinational. Writes take effect at the rising clock edge, so a read in the same cycle as a write to the same entry returns the old contents.

Top module: `paired_regfile`

## Requirements
- R1: A synchronous active-high reset clears every entry to zero, so that in the first cycle after reset every read port returns zero.
- R2: When `wr_en` is high, `wr_data` is stored in entry `wr_idx` at the rising edge. `rd_a_data` and `rd_b_data` combinationally return entry `rd_a_idx` and `rd_b_idx`, and a read in the same cycle as a write to the same entry returns the old value.
- R3: Entry 0 always reads as zero and any write to it is discarded. This holds through both read ports, base alias 0, index alias 0, modification alias 0 and the upper half of floating register 0.
- R4: For a legal floating number n, `fp_rd_data[63:32]` is entry n and `fp_rd_data[31:0]` is entry n+16. This covers 0..15 (pairs with 16..31) and 32..47 (pairs with 48..63).
- R5: A 64-bit write (`fp_wr_en` high, `fp_wr_single` low, legal number n) stores `fp_wr_data[63:32]` in entry n and `fp_wr_data[31:0]` in entry n+16 at the same edge. For n = 0 only entry 16 changes.
- R6: A single-precision write (`fp_wr_en` and `fp_wr_single` high, legal n) stores `fp_wr_data[63:32]` in entry n only and leaves entry n+16 unchanged.
- R7: A floating number whose bit 4 is set (16..31, 48..63) is illegal. The matching flag `fp_rd_illegal` or `fp_wr_illegal` is high, an illegal read returns zero, and an illegal write changes no entry.
- R8: Base alias `base_num` and index alias `index_num` (4 bits each) return entry 0..15 of the same number.
- R9: Modification alias `mod_num` = m, for m from 1 to 15, returns entry 16+m. Alias 0 returns zero.
- R10: When the scalar write and a floating write target the same entry in the same cycle, the floating write's value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 6 | Entry number for read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 6 | Entry number for read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | Scalar write enable |
| wr_idx | input | 6 | Scalar write entry number |
| wr_data | input | 32 | Scalar write data |
| fp_rd_num | input | 6 | Floating register number for the 64-bit read |
| fp_rd_data | output | 64 | Pair read data, upper word from entry n |
| fp_rd_illegal | output | 1 | Read floating number out of range |
| fp_wr_en | input | 1 | Floating write enable |
| fp_wr_single | input | 1 | High: write the upper word only |
| fp_wr_num | input | 6 | Floating register number for the write |
| fp_wr_data | input | 64 | Floating write data |
| fp_wr_illegal | output | 1 | Write floating number out of range |
| base_num | input | 4 | Base alias number |
| base_data | output | 32 | Base alias data |
| index_num | input | 4 | Index alias number |
| index_data | output | 32 | Index alias data |
| mod_num | input | 4 | Modification alias number |
| mod_data | output | 32 | Modification alias data |

## Verification
The hardest case to reach from the ports is a collision: the scalar port and a floating write land on the same entry at the same edge, either on the upper or on the lower word of a pair. The same applies to floating writes that touch entry zero through register 0. Random traffic seldom lines up those indices, so the bench drives each collision on purpose with chosen numbers before a long random phase. In that phase a behavioural model of the sixty-four words predicts every output on every cycle.

// File: rtl/pvrf_pkg.sv
package pvrf_pkg;

    parameter int DATA_W      = 32;
    parameter int NUM_REGS    = 64;
    parameter int ALIAS_W     = 4;
    parameter int PAIR_STRIDE = 16;

    localparam int IDX_W      = $clog2(NUM_REGS);
    localparam int STRIDE_BIT = $clog2(PAIR_STRIDE);
    localparam int DWORD_W    = 2 * DATA_W;

    typedef logic [DATA_W-1:0]  word_t;
    typedef logic [DWORD_W-1:0] dword_t;
    typedef logic [IDX_W-1:0]   idx_t;
    typedef logic [ALIAS_W-1:0] alias_t;

    // One write request into the storage bank
    typedef struct packed {
        logic  en;
        idx_t  idx;
        word_t data;
    } wport_t;

    // Result of decoding a floating register number
    typedef struct packed {
        logic legal;
        idx_t hi;
        idx_t lo;
    } fpair_t;

    function automatic fpair_t fpair_decode(idx_t num);
        fpair_t r;
        r.legal = (num[STRIDE_BIT] == 1'b0);
        r.hi    = num;
        r.lo    = num + idx_t'(PAIR_STRIDE);
        return r;
    endfunction

endpackage

// File: rtl/pvrf_pair_map.sv
module pvrf_pair_map
    import pvrf_pkg::*;
(
    input  idx_t   fnum,
    output fpair_t pmap
);
    assign pmap = fpair_decode(fnum);
endmodule

// File: rtl/pvrf_alias_map.sv
module pvrf_alias_map
    import pvrf_pkg::*;
#(
    parameter int OFFSET    = 0,
    parameter bit ZERO_HOLD = 1'b0
) (
    input  alias_t anum,
    output idx_t   eidx
);
    generate
        if (ZERO_HOLD) begin : g_zero_hold
            // Alias zero stays on the hard-zero entry
            assign eidx = (anum == '0) ? '0 : idx_t'(OFFSET) + idx_t'(anum);
        end else begin : g_plain
            assign eidx = idx_t'(OFFSET) + idx_t'(anum);
        end
    endgenerate
endmodule

// File: rtl/pvrf_storage.sv
module pvrf_storage
    import pvrf_pkg::*;
#(
    parameter int NRP = 7,
    parameter int NWP = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  wport_t [NWP-1:0]   wports,
    input  idx_t   [NRP-1:0]   raddr,
    output word_t  [NRP-1:0]   rdata
);
    word_t [NUM_REGS-1:0] bank;

    generate
        for (genvar e = 0; e < NUM_REGS; e++) begin : g_entry
            if (e == 0) begin : g_zero
                assign bank[e] = '0;
            end else begin : g_live
                word_t q;
                always_ff @(posedge clk) begin
                    if (rst) begin
                        q <= '0;
                    end else begin
                        // Later ports override earlier ones
                        for (int p = 0; p < NWP; p++) begin
                            if (wports[p].en && (wports[p].idx == idx_t'(e))) begin
                                q <= wports[p].data;
                            end
                        end
                    end
                end
                assign bank[e] = q;
            end
        end

        for (genvar r = 0; r < NRP; r++) begin : g_read
            assign rdata[r] = bank[raddr[r]];
        end
    endgenerate
endmodule

// File: rtl/paired_regfile.sv
module paired_regfile
    import pvrf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [IDX_W-1:0]    rd_a_idx,
    output logic [DATA_W-1:0]   rd_a_data,
    input  logic [IDX_W-1:0]    rd_b_idx,
    output logic [DATA_W-1:0]   rd_b_data,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [IDX_W-1:0]    fp_rd_num,
    output logic [DWORD_W-1:0]  fp_rd_data,
    output logic                fp_rd_illegal,
    input  logic                fp_wr_en,
    input  logic                fp_wr_single,
    input  logic [IDX_W-1:0]    fp_wr_num,
    input  logic [DWORD_W-1:0]  fp_wr_data,
    output logic                fp_wr_illegal,
    input  logic [ALIAS_W-1:0]  base_num,
    output logic [DATA_W-1:0]   base_data,
    input  logic [ALIAS_W-1:0]  index_num,
    output logic [DATA_W-1:0]   index_data,
    input  logic [ALIAS_W-1:0]  mod_num,
    output logic [DATA_W-1:0]   mod_data
);
    localparam int RP_A   = 0;
    localparam int RP_B   = 1;
    localparam int RP_FHI = 2;
    localparam int RP_FLO = 3;
    localparam int RP_BAS = 4;
    localparam int RP_IDX = 5;
    localparam int RP_MOD = 6;
    localparam int NRP    = 7;

    localparam int WP_SCL = 0;
    localparam int WP_FHI = 1;
    localparam int WP_FLO = 2;
    localparam int NWP    = 3;

    fpair_t rd_pair;
    fpair_t wr_pair;
    idx_t   base_eidx;
    idx_t   index_eidx;
    idx_t   mod_eidx;

    wport_t [NWP-1:0] wports;
    idx_t   [NRP-1:0] raddr;
    word_t  [NRP-1:0] rdata;

    pvrf_pair_map u_rd_map (.fnum(fp_rd_num), .pmap(rd_pair));
    pvrf_pair_map u_wr_map (.fnum(fp_wr_num), .pmap(wr_pair));

    pvrf_alias_map #(.OFFSET(0), .ZERO_HOLD(1'b0)) u_base_map
        (.anum(base_num), .eidx(base_eidx));
    pvrf_alias_map #(.OFFSET(0), .ZERO_HOLD(1'b0)) u_index_map
        (.anum(index_num), .eidx(index_eidx));
    pvrf_alias_map #(.OFFSET(PAIR_STRIDE), .ZERO_HOLD(1'b1)) u_mod_map
        (.anum(mod_num), .eidx(mod_eidx));

    always_comb begin
        raddr[RP_A]   = rd_a_idx;
        raddr[RP_B]   = rd_b_idx;
        raddr[RP_FHI] = rd_pair.hi;
        raddr[RP_FLO] = rd_pair.lo;
        raddr[RP_BAS] = base_eidx;
        raddr[RP_IDX] = index_eidx;
        raddr[RP_MOD] = mod_eidx;
    end

    always_comb begin
        wports[WP_SCL].en   = wr_en;
        wports[WP_SCL].idx  = wr_idx;
        wports[WP_SCL].data = wr_data;
        wports[WP_FHI].en   = fp_wr_en && wr_pair.legal;
        wports[WP_FHI].idx  = wr_pair.hi;
        wports[WP_FHI].data = fp_wr_data[DWORD_W-1:DATA_W];
        wports[WP_FLO].en   = fp_wr_en && wr_pair.legal && !fp_wr_single;
        wports[WP_FLO].idx  = wr_pair.lo;
        wports[WP_FLO].data = fp_wr_data[DATA_W-1:0];
    end

    pvrf_storage #(.NRP(NRP), .NWP(NWP)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wports (wports),
        .raddr  (raddr),
        .rdata  (rdata)
    );

    assign rd_a_data     = rdata[RP_A];
    assign rd_b_data     = rdata[RP_B];
    assign fp_rd_data    = rd_pair.legal ? {rdata[RP_FHI], rdata[RP_FLO]} : '0;
    assign fp_rd_illegal = !rd_pair.legal;
    assign fp_wr_illegal = !wr_pair.legal;
    assign base_data     = rdata[RP_BAS];
    assign index_data    = rdata[RP_IDX];
    assign mod_data      = rdata[RP_MOD];
endmodule

// File: rtl/pvrf_checker.sv
module pvrf_checker
    import pvrf_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [IDX_W-1:0]    rd_a_idx,
    input logic [DATA_W-1:0]   rd_a_data,
    input logic [IDX_W-1:0]    rd_b_idx,
    input logic [DATA_W-1:0]   rd_b_data,
    input logic                wr_en,
    input logic [IDX_W-1:0]    wr_idx,
    input logic [DATA_W-1:0]   wr_data,
    input logic [IDX_W-1:0]    fp_rd_num,
    input logic [DWORD_W-1:0]  fp_rd_data,
    input logic                fp_rd_illegal,
    input logic                fp_wr_en,
    input logic                fp_wr_single,
    input logic [IDX_W-1:0]    fp_wr_num,
    input logic [DWORD_W-1:0]  fp_wr_data,
    input logic                fp_wr_illegal,
    input logic [ALIAS_W-1:0]  base_num,
    input logic [DATA_W-1:0]   base_data,
    input logic [ALIAS_W-1:0]  index_num,
    input logic [DATA_W-1:0]   index_data,
    input logic [ALIAS_W-1:0]  mod_num,
    input logic [DATA_W-1:0]   mod_data
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_a_data == '0 && rd_b_data == '0 && fp_rd_data == '0));

    // R2
    write_then_read_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx != '0 && !fp_wr_en) |=>
        (rd_a_idx != $past(wr_idx) || rd_a_data == $past(wr_data)));

    // R3
    zero_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == '0) |-> (rd_a_data == '0));

    // R3
    zero_fp_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (fp_rd_num == '0) |-> (fp_rd_data[DWORD_W-1:DATA_W] == '0));

    // R3
    zero_mod_chk: assert property (@(posedge clk) disable iff (rst)
        (mod_num == '0) |-> (mod_data == '0));

    // R4
    pair_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (!fp_rd_illegal && rd_b_idx == fp_rd_num) |->
        (fp_rd_data[DWORD_W-1:DATA_W] == rd_b_data));

    // R4
    pair_lower_chk: assert property (@(posedge clk) disable iff (rst)
        (!fp_rd_illegal && rd_a_idx == fp_rd_num + IDX_W'(PAIR_STRIDE)) |->
        (fp_rd_data[DATA_W-1:0] == rd_a_data));

    // R5
    pair_write_chk: assert property (@(posedge clk) disable iff (rst)
        (fp_wr_en && !fp_wr_illegal && !fp_wr_single && fp_wr_num != '0) |=>
        (fp_rd_num != $past(fp_wr_num) || fp_rd_data == $past(fp_wr_data)));

    // R7
    illegal_read_chk: assert property (@(posedge clk) disable iff (rst)
        fp_rd_illegal |-> (fp_rd_data == '0));

    // R8
    base_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == IDX_W'(base_num)) |-> (base_data == rd_a_data));

    // R8
    index_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_b_idx == IDX_W'(index_num)) |-> (index_data == rd_b_data));

    // R9
    mod_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (mod_num != '0 && rd_b_idx == IDX_W'(mod_num) + IDX_W'(PAIR_STRIDE)) |->
        (mod_data == rd_b_data));

    // R10
    collide_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fp_wr_en && !fp_wr_illegal && wr_idx == fp_wr_num && wr_idx != '0) |=>
        (rd_a_idx != $past(wr_idx) || rd_a_data == $past(fp_wr_data[DWORD_W-1:DATA_W])));
endmodule

bind paired_regfile pvrf_checker u_pvrf_checker (
    .clk           (clk),
    .rst           (rst),
    .rd_a_idx      (rd_a_idx),
    .rd_a_data     (rd_a_data),
    .rd_b_idx      (rd_b_idx),
    .rd_b_data     (rd_b_data),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .wr_data       (wr_data),
    .fp_rd_num     (fp_rd_num),
    .fp_rd_data    (fp_rd_data),
    .fp_rd_illegal (fp_rd_illegal),
    .fp_wr_en      (fp_wr_en),
    .fp_wr_single  (fp_wr_single),
    .fp_wr_num     (fp_wr_num),
    .fp_wr_data    (fp_wr_data),
    .fp_wr_illegal (fp_wr_illegal),
    .base_num      (base_num),
    .base_data     (base_data),
    .index_num     (index_num),
    .index_data    (index_data),
    .mod_num       (mod_num),
    .mod_data      (mod_data)
);

// File: tb/paired_regfile_bench.sv
`timescale 1ns/1ps
module paired_regfile_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, fp_rd_num = '0, fp_wr_num = '0;
    logic [31:0] wr_data = '0;
    logic        wr_en = 1'b0, fp_wr_en = 1'b0, fp_wr_single = 1'b0;
    logic [63:0] fp_wr_data = '0;
    logic [3:0]  base_num = '0, index_num = '0, mod_num = '0;
    logic [31:0] rd_a_data, rd_b_data, base_data, index_data, mod_data;
    logic [63:0] fp_rd_data;
    logic        fp_rd_illegal, fp_wr_illegal;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;
    logic [31:0] mdl [64];

    always #10 clk = ~clk;

    paired_regfile u_paired_regfile (.*);

    function automatic bit m_legal(int n);
        return (n < 16) || (n >= 32 && n < 48);
    endfunction

    function automatic logic [31:0] m_rd(int i);
        return (i == 0) ? 32'h0 : mdl[i];
    endfunction

    function automatic logic [63:0] m_fp(int n);
        return m_legal(n) ? {m_rd(n), m_rd(n + 16)} : 64'h0;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            for (int i = 0; i < 64; i++) mdl[i] = '0;
        end else begin
            if (wr_en && wr_idx != 0) mdl[wr_idx] = wr_data;
            if (fp_wr_en && m_legal(int'(fp_wr_num))) begin
                if (fp_wr_num != 0) mdl[fp_wr_num] = fp_wr_data[63:32];
                if (!fp_wr_single) mdl[int'(fp_wr_num) + 16] = fp_wr_data[31:0];
            end
        end
    endtask

    // Compare every output to the model, then cross one edge
    task automatic step();
        #2;
        chk("R2 port A", {32'h0, rd_a_data}, {32'h0, m_rd(int'(rd_a_idx))});
        chk("R2 port B", {32'h0, rd_b_data}, {32'h0, m_rd(int'(rd_b_idx))});
        chk("R4 pair read", fp_rd_data, m_fp(int'(fp_rd_num)));
        chk("R7 read flag", {63'h0, fp_rd_illegal}, {63'h0, !m_legal(int'(fp_rd_num))});
        chk("R7 write flag", {63'h0, fp_wr_illegal}, {63'h0, !m_legal(int'(fp_wr_num))});
        chk("R8 base", {32'h0, base_data}, {32'h0, m_rd(int'(base_num))});
        chk("R8 index", {32'h0, index_data}, {32'h0, m_rd(int'(index_num))});
        chk("R9 mod", {32'h0, mod_data},
            {32'h0, (mod_num == 0) ? 32'h0 : m_rd(16 + int'(mod_num))});
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic quiet();
        wr_en = 1'b0; fp_wr_en = 1'b0; fp_wr_single = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mdl[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: every entry reads zero after reset
        for (int i = 0; i < 64; i++) begin
            rd_a_idx = 6'(i);
            #1;
            chk("R1 reset clear", {32'h0, rd_a_data}, 64'h0);
            step();
        end

        // R2: same-cycle read sees old value, next cycle the new one
        wr_en = 1'b1; wr_idx = 6'd5; wr_data = 32'hCAFE_0005; rd_a_idx = 6'd5;
        #1 chk("R2 old value", {32'h0, rd_a_data}, 64'h0);
        step(); quiet();
        #1 chk("R2 new value", {32'h0, rd_a_data}, 64'h0000_0000_CAFE_0005);
        step();

        // R3: writes to entry 0 vanish under every view
        wr_en = 1'b1; wr_idx = 6'd0; wr_data = 32'hFFFF_FFFF;
        step(); quiet();
        rd_a_idx = 0; base_num = 0; index_num = 0; mod_num = 0; fp_rd_num = 0;
        #1;
        chk("R3 port A", {32'h0, rd_a_data}, 64'h0);
        chk("R3 base", {32'h0, base_data}, 64'h0);
        chk("R3 mod alias 0", {32'h0, mod_data}, 64'h0);
        chk("R3 pair upper", {32'h0, fp_rd_data[63:32]}, 64'h0);
        step();

        // R5: full pair writes, both banks, and register zero
        fp_wr_en = 1'b1; fp_wr_num = 6'd3; fp_wr_data = 64'h1111_2222_3333_4444;
        step();
        fp_wr_num = 6'd40; fp_wr_data = 64'h5555_6666_7777_8888;
        step();
        fp_wr_num = 6'd0; fp_wr_data = 64'h9999_AAAA_BBBB_CCCC;
        step(); quiet();
        fp_rd_num = 6'd3; rd_a_idx = 6'd3; rd_b_idx = 6'd19;
        #1;
        chk("R5 pair 3", fp_rd_data, 64'h1111_2222_3333_4444);
        chk("R5 upper word", {32'h0, rd_a_data}, 64'h1111_2222);
        chk("R5 lower word", {32'h0, rd_b_data}, 64'h3333_4444);
        step();
        fp_rd_num = 6'd40; rd_b_idx = 6'd56;
        #1;
        chk("R5 pair 40", fp_rd_data, 64'h5555_6666_7777_8888);
        chk("R5 entry 56", {32'h0, rd_b_data}, 64'h7777_8888);
        step();
        fp_rd_num = 6'd0; rd_a_idx = 6'd16;
        #1;
        chk("R5 pair 0", fp_rd_data, 64'h0000_0000_BBBB_CCCC);
        chk("R5 entry 16", {32'h0, rd_a_data}, 64'hBBBB_CCCC);
        step();

        // R6: single precision writes the upper word only
        wr_en = 1'b1; wr_idx = 6'd21; wr_data = 32'h0BAD_0021;
        step(); quiet();
        fp_wr_en = 1'b1; fp_wr_single = 1'b1; fp_wr_num = 6'd5;
        fp_wr_data = 64'hDEAD_BEEF_FFFF_FFFF;
        step(); quiet();
        rd_a_idx = 6'd5; rd_b_idx = 6'd21;
        #1;
        chk("R6 upper", {32'h0, rd_a_data}, 64'hDEAD_BEEF);
        chk("R6 lower kept", {32'h0, rd_b_data}, 64'h0BAD_0021);
        step();

        // R7: illegal numbers flag and write nothing
        fp_wr_en = 1'b1; fp_wr_num = 6'd20; fp_wr_data = 64'h0123_4567_89AB_CDEF;
        #1 chk("R7 flag 20", {63'h0, fp_wr_illegal}, 64'h1);
        step();
        fp_wr_num = 6'd50;
        #1 chk("R7 flag 50", {63'h0, fp_wr_illegal}, 64'h1);
        step(); quiet();
        rd_a_idx = 6'd20; rd_b_idx = 6'd36; fp_rd_num = 6'd20;
        #1;
        chk("R7 entry 20 kept", {32'h0, rd_a_data}, 64'h0);
        chk("R7 entry 36 kept", {32'h0, rd_b_data}, 64'h0);
        chk("R7 read zero", fp_rd_data, 64'h0);
        step();
        rd_a_idx = 6'd50; rd_b_idx = 6'd2;
        #1;
        chk("R7 entry 50 kept", {32'h0, rd_a_data}, 64'h0);
        chk("R7 entry 2 kept", {32'h0, rd_b_data}, 64'h0);
        step();

        // R8 and R9: alias lookups
        wr_en = 1'b1; wr_idx = 6'd7; wr_data = 32'h7777_0007;
        step();
        wr_idx = 6'd25; wr_data = 32'h2525_0025;
        step(); quiet();
        base_num = 4'd7; index_num = 4'd7; mod_num = 4'd9;
        #1;
        chk("R8 base 7", {32'h0, base_data}, 64'h7777_0007);
        chk("R8 index 7", {32'h0, index_data}, 64'h7777_0007);
        chk("R9 mod 9", {32'h0, mod_data}, 64'h2525_0025);
        step();

        // R10: pair write beats scalar write on the same entry
        wr_en = 1'b1; wr_idx = 6'd35; wr_data = 32'h5CA1_A500;
        fp_wr_en = 1'b1; fp_wr_num = 6'd35; fp_wr_data = 64'hF10A_7000_0000_0051;
        step();
        fp_wr_num = 6'd10; wr_idx = 6'd26; wr_data = 32'h5CA1_A526;
        fp_wr_data = 64'h0000_00AA_F10A_7026;
        step(); quiet();
        rd_a_idx = 6'd35; rd_b_idx = 6'd26;
        #1;
        chk("R10 upper collide", {32'h0, rd_a_data}, 64'hF10A_7000);
        chk("R10 lower collide", {32'h0, rd_b_data}, 64'hF10A_7026);
        step();

        // Random traffic against the model
        for (int c = 0; c < 4000; c++) begin
            wr_en        = ($urandom % 2) == 0;
            wr_idx       = 6'($urandom);
            wr_data      = $urandom;
            fp_wr_en     = ($urandom % 4) == 0;
            fp_wr_single = ($urandom % 3) == 0;
            fp_wr_num    = 6'($urandom);
            fp_wr_data   = {$urandom, $urandom};
            rd_a_idx     = 6'($urandom);
            rd_b_idx     = 6'($urandom);
            fp_rd_num    = 6'($urandom);
            base_num     = 4'($urandom);
            index_num    = 4'($urandom);
            mod_num      = 4'($urandom);
            step();
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog act=running exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule